// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two independent ports of a shared memory and decides who yields when both ports select the same word at once. Each port has an active-low select, an active-low write strobe and an address. While both ports are selected on one address, the arbiter pulls an active-low busy flag for exactly one of them. That port is the one whose request settled later. The block also removes that port's write, so the memory never sees two competing writes to one word.

Request timing is resolved per clock cycle. A port's request becomes new in the cycle where its select first goes active or its address changes while selected. If one port's matching request is new in a later cycle than the other's, the later port loses. If both become new in the same cycle, the left port wins. Once a collision is resolved, its outcome is held for as long as both ports stay selected on the unchanged shared address.

A mode input chooses how the busy flags are used. In master mode the block drives both flags as push-pull outputs and gates writes from its own decision. In slave mode the flags come from another arbiter through the busy inputs and are used only to block writes. In that mode the block's own flag outputs stay released high with their drive enable low. The outputs are combinational on the current inputs plus one cycle of registered request history.

Top module: `dp_collision_arbiter`

## Requirements
- R1: After synchronous reset, with both ports deselected, both busy outputs are high and both write enables are low.
- R2: In master mode, both busy outputs are high whenever either select is high (inactive) or the two addresses differ.
- R3: In master mode, when both ports are selected on the same address and one port's request became new in a later cycle than the other's, only the later port's busy output is low. A request is new in the cycle its select goes low or its address changes while selected.
- R4: In master mode, when both matching requests become new in the same cycle, the right busy output goes low and the left stays high.
- R5: The two busy outputs are never low together.
- R6: A resolved collision keeps the same busy port while both selects stay low and neither address changes. The collision ends, in the same cycle, when either select goes high or the addresses differ.
- R7: In master mode a port whose busy output is low has its write enable low even with its write strobe low; the other port's write is passed.
- R8: In slave mode both busy outputs are high and busy_oe is low. A port's write enable is then blocked exactly when that port's busy input is low.
- R9: In master mode busy_oe is high and the busy inputs have no effect on the write enables.
- R10: A write enable is high only while its port's select and write strobe are both low and the port is not blocked. A read (strobe high) never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_master | input | 1 | 1: drive busy flags from own decision; 0: take busy from inputs |
| l_ce_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | ADDR_W | Left port address |
| r_ce_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | External busy for the left port (slave mode), active low |
| r_busy_in_n | input | 1 | External busy for the right port (slave mode), active low |
| l_busy_n | output | 1 | Left busy flag, active low, released high in slave mode |
| r_busy_n | output | 1 | Right busy flag, active low, released high in slave mode |
| busy_oe | output | 1 | Drive enable for both busy flags (push-pull), high in master mode |
| l_wr_en | output | 1 | Qualified left write to the memory, active high |
| r_wr_en | output | 1 | Qualified right write to the memory, active high |

## Verification
The bench builds the block with ADDR_W set to 3 and draws random addresses from only four values. This keeps same-address collisions, late arrivals from either side, and simultaneous arrivals frequent under random stimulus. With the narrow address, address changes during a held collision and re-collisions on a new shared word occur many times in a few thousand cycles. Random mode flips with randomly driven busy inputs exercise slave-mode gating and the master-mode disregard of those inputs.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int NUM_PORTS  = 2;
    localparam int PORT_LEFT  = 0;
    localparam int PORT_RIGHT = 1;

    // Which port, if any, must yield on the shared address
    typedef enum logic [1:0] {
        LOSE_NONE  = 2'd0,
        LOSE_LEFT  = 2'd1,
        LOSE_RIGHT = 2'd2
    } loser_e;

    // Per-port request view derived from one cycle of history
    typedef struct packed {
        logic act;     // port selected this cycle
        logic fresh;   // request settled this cycle
        logic wr_req;  // port selected and strobing a write
    } port_req_t;

    // Later arrival loses; a tie goes against the right port
    function automatic loser_e first_come(input logic l_fresh, input logic r_fresh);
        if (l_fresh && !r_fresh)
            return LOSE_LEFT;
        return LOSE_RIGHT;
    endfunction

    function automatic logic port_lost(input loser_e who, input int unsigned port);
        if (port == PORT_LEFT)
            return who == LOSE_LEFT;
        return who == LOSE_RIGHT;
    endfunction

endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req
);

    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic              act;

    assign act = ~ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            act_q  <= act;
            addr_q <= addr;
        end
    end

    always_comb begin
        req.act    = act;
        req.fresh  = act && (!act_q || (addr != addr_q));
        req.wr_req = act && !we_n;
    end

endmodule

// File: rtl/dpc_collide.sv
module dpc_collide
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_act,
    input  logic              l_fresh,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_act,
    input  logic              r_fresh,
    input  logic [ADDR_W-1:0] r_addr,
    output loser_e            loser
);

    loser_e loser_q;
    logic   match;
    logic   held;

    always_comb begin
        match = l_act && r_act && (l_addr == r_addr);
        held  = (loser_q != LOSE_NONE) && match && !l_fresh && !r_fresh;
        if (!match)
            loser = LOSE_NONE;
        else if (held)
            loser = loser_q;
        else
            loser = first_come(l_fresh, r_fresh);
    end

    always_ff @(posedge clk) begin
        if (rst)
            loser_q <= LOSE_NONE;
        else
            loser_q <= loser;
    end

endmodule

// File: rtl/dpc_busy_gate.sv
module dpc_busy_gate
    import dpc_pkg::*;
#(
    parameter int unsigned PORT = 0
) (
    input  logic   is_master,
    input  loser_e loser,
    input  logic   busy_in_n,
    input  logic   wr_req,
    output logic   busy_n,
    output logic   wr_en
);

    logic own_busy;
    logic blocked;

    always_comb begin
        own_busy = port_lost(loser, PORT);
        blocked  = is_master ? own_busy : !busy_in_n;
        busy_n   = is_master ? !own_busy : 1'b1;
        wr_en    = wr_req && !blocked;
    end

endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              busy_oe,
    output logic              l_wr_en,
    output logic              r_wr_en
);

    logic [NUM_PORTS-1:0] ce_n_v;
    logic [NUM_PORTS-1:0] we_n_v;
    logic [NUM_PORTS-1:0] bin_v;
    logic [NUM_PORTS-1:0] busy_v;
    logic [NUM_PORTS-1:0] wr_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    port_req_t            req_v  [NUM_PORTS];
    loser_e               loser;

    assign ce_n_v[PORT_LEFT]  = l_ce_n;
    assign ce_n_v[PORT_RIGHT] = r_ce_n;
    assign we_n_v[PORT_LEFT]  = l_we_n;
    assign we_n_v[PORT_RIGHT] = r_we_n;
    assign bin_v[PORT_LEFT]   = l_busy_in_n;
    assign bin_v[PORT_RIGHT]  = r_busy_in_n;
    assign addr_v[PORT_LEFT]  = l_addr;
    assign addr_v[PORT_RIGHT] = r_addr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpc_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk  (clk),
            .rst  (rst),
            .ce_n (ce_n_v[p]),
            .we_n (we_n_v[p]),
            .addr (addr_v[p]),
            .req  (req_v[p])
        );

        dpc_busy_gate #(.PORT(p)) u_gate (
            .is_master (is_master),
            .loser     (loser),
            .busy_in_n (bin_v[p]),
            .wr_req    (req_v[p].wr_req),
            .busy_n    (busy_v[p]),
            .wr_en     (wr_v[p])
        );
    end

    dpc_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk     (clk),
        .rst     (rst),
        .l_act   (req_v[PORT_LEFT].act),
        .l_fresh (req_v[PORT_LEFT].fresh),
        .l_addr  (addr_v[PORT_LEFT]),
        .r_act   (req_v[PORT_RIGHT].act),
        .r_fresh (req_v[PORT_RIGHT].fresh),
        .r_addr  (addr_v[PORT_RIGHT]),
        .loser   (loser)
    );

    assign l_busy_n = busy_v[PORT_LEFT];
    assign r_busy_n = busy_v[PORT_RIGHT];
    assign l_wr_en  = wr_v[PORT_LEFT];
    assign r_wr_en  = wr_v[PORT_RIGHT];
    assign busy_oe  = is_master;

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              is_master,
    input logic              l_ce_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              busy_oe,
    input logic              l_wr_en,
    input logic              r_wr_en
);

    logic same;
    assign same = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n)); // R5

    AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (is_master && !same) |-> (l_busy_n && r_busy_n)); // R2

    AST_TIE_RIGHT_LOSES: assert property (@(posedge clk) disable iff (rst)
        (is_master && same && $past(!rst) && $past(l_ce_n) && $past(r_ce_n))
        |-> (!r_busy_n && l_busy_n)); // R4

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (is_master && $past(is_master) && $past(!rst) && same && $past(same)
         && $stable(l_addr) && $stable(r_addr) && $past(!l_busy_n))
        |-> !l_busy_n); // R6

    AST_BUSY_NO_WRITE_L: assert property (@(posedge clk) disable iff (rst)
        (is_master && !l_busy_n) |-> !l_wr_en); // R7

    AST_BUSY_NO_WRITE_R: assert property (@(posedge clk) disable iff (rst)
        (is_master && !r_busy_n) |-> !r_wr_en); // R7

    AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> (l_busy_n && r_busy_n && !busy_oe)); // R8

    AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (l_wr_en |-> (!l_ce_n && !l_we_n)) and (r_wr_en |-> (!r_ce_n && !r_we_n))); // R10

endmodule

bind dp_collision_arbiter dpc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .is_master (is_master),
    .l_ce_n    (l_ce_n),
    .l_we_n    (l_we_n),
    .l_addr    (l_addr),
    .r_ce_n    (r_ce_n),
    .r_we_n    (r_we_n),
    .r_addr    (r_addr),
    .l_busy_n  (l_busy_n),
    .r_busy_n  (r_busy_n),
    .busy_oe   (busy_oe),
    .l_wr_en   (l_wr_en),
    .r_wr_en   (r_wr_en)
);

// File: tb/sim_dp_collision_arbiter.sv
`timescale 1ns/1ps
module sim_dp_collision_arbiter;

    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic is_master = 1'b1;
    logic l_ce_n = 1'b1, l_we_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic l_busy_n, r_busy_n, busy_oe, l_wr_en, r_wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state: previous cycle and last resolved loser (0 none, 1 left, 2 right)
    bit          m_la_q = 0, m_ra_q = 0;
    bit [AW-1:0] m_laddr_q = '0, m_raddr_q = '0;
    int          m_loser = 0;

    always #2.5 clk = ~clk;

    dp_collision_arbiter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .is_master(is_master),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .busy_oe(busy_oe),
        .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Expected loser for the current inputs from the arrival rules
    function automatic int exp_loser(output bit held, output bit tie, output bit match);
        bit la, ra, lf, rf;
        la = !l_ce_n; ra = !r_ce_n;
        match = la && ra && (l_addr == r_addr);
        lf = la && (!m_la_q || l_addr != m_laddr_q);
        rf = ra && (!m_ra_q || r_addr != m_raddr_q);
        held = (m_loser != 0) && match && !lf && !rf;
        tie = lf && rf;
        if (!match) return 0;
        if (held) return m_loser;
        if (lf && !rf) return 1;
        return 2;
    endfunction

    // One cycle: drive at negedge, check before posedge, update model
    task automatic step(input bit m, input bit lce, input bit lwe, input bit [AW-1:0] la,
                        input bit rce, input bit rwe, input bit [AW-1:0] ra,
                        input bit lbi, input bit rbi);
        int  lo;
        bit  held, tie, match, lblk, rblk;
        string bt;
        @(negedge clk);
        is_master = m; l_ce_n = lce; l_we_n = lwe; l_addr = la;
        r_ce_n = rce; r_we_n = rwe; r_addr = ra;
        l_busy_in_n = lbi; r_busy_in_n = rbi;
        #1;
        lo = exp_loser(held, tie, match);
        if (!m)          bt = "R8";
        else if (!match) bt = "R2";
        else if (held)   bt = "R6";
        else if (tie)    bt = "R4";
        else             bt = "R3";
        chk(bt, "l_busy_n", l_busy_n, m ? (lo != 1) : 1'b1);
        chk(bt, "r_busy_n", r_busy_n, m ? (lo != 2) : 1'b1);
        chk("R5", "not both busy", !(!l_busy_n && !r_busy_n), 1'b1);
        chk(m ? "R9" : "R8", "busy_oe", busy_oe, m);
        lblk = m ? (lo == 1) : !lbi;
        rblk = m ? (lo == 2) : !rbi;
        chk(m ? (lblk ? "R7" : (!lbi ? "R9" : "R10")) : "R8", "l_wr_en", l_wr_en,
            !lce && !lwe && !lblk);
        chk(m ? (rblk ? "R7" : (!rbi ? "R9" : "R10")) : "R8", "r_wr_en", r_wr_en,
            !rce && !rwe && !rblk);
        @(posedge clk);
        m_la_q = !lce; m_ra_q = !rce; m_laddr_q = la; m_raddr_q = ra; m_loser = lo;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle outputs after reset
        chk("R1", "l_busy_n", l_busy_n, 1'b1);
        chk("R1", "r_busy_n", r_busy_n, 1'b1);
        chk("R1", "l_wr_en", l_wr_en, 1'b0);
        chk("R1", "r_wr_en", r_wr_en, 1'b0);
        @(posedge clk);

        // R3: left first on 5, right arrives later -> right busy, right write dropped (R7)
        step(1, 0,0,3'd5, 1,1,3'd5, 1,1);
        step(1, 0,0,3'd5, 0,0,3'd5, 1,1);
        // R6: hold for several cycles
        step(1, 0,0,3'd5, 0,0,3'd5, 1,1);
        step(1, 0,1,3'd5, 0,0,3'd5, 0,0);
        // R6: left leaves -> collision over
        step(1, 0,0,3'd2, 0,0,3'd5, 1,1);
        // R3: left returns later -> left busy
        step(1, 0,0,3'd5, 0,0,3'd5, 1,1);
        step(1, 0,0,3'd5, 0,0,3'd5, 1,1);
        // R2: deselect
        step(1, 1,0,3'd5, 0,0,3'd5, 1,1);
        step(1, 1,1,3'd0, 1,1,3'd0, 1,1);
        // R4: simultaneous arrival
        step(1, 0,0,3'd7, 0,0,3'd7, 1,1);
        step(1, 0,0,3'd7, 0,0,3'd7, 1,1);
        // R8: slave mode follows busy inputs
        step(0, 0,0,3'd7, 0,0,3'd7, 0,1);
        step(0, 0,0,3'd7, 0,0,3'd7, 1,0);
        step(0, 0,1,3'd1, 0,0,3'd2, 1,1);

        for (int i = 0; i < 4000; i++) begin
            bit m;
            m = ($urandom_range(0, 9) != 0);
            step(m,
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 1), 3'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 1), 3'($urandom_range(0, 3)),
                 $urandom_range(0, 1), $urandom_range(0, 1));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule